// File: doc/BRIEF.md
# Byte AND Executor with Selectable Destination

This block carries out a single byte-wide logical AND between the working register and one data-memory byte. The memory byte is picked by an 8-bit file field carried in a 16-bit instruction word. The 12-bit data address can come from three sources. In banked mode a 4-bit bank register supplies the upper bits. In access mode the byte lives in a fixed window that joins the bottom and top of the data space. In indexed mode a 12-bit pointer is added to the file field, and this mode applies only to low file values when the extended mode input is set.

Execution takes four fixed phases after an instruction is accepted:

1. Decode, which fixes the address.
2. Read, which presents a synchronous read to data memory.
3. Process, which forms the AND.
4. Write, which commits the result.

In the write phase the result goes back to the same memory byte or to the working register, depending on a destination bit. The negative and zero flags follow the result. The working register is held outside the block: it is read through `w_in` and updated through a write strobe.

Top module: `fileop_and_core`

## Requirements
- R1: Only an instruction whose bits [15:10] equal 6'b000101, presented with `issue` high while the block is idle, is accepted. Any other word causes no memory read, no write and no `done`.
- R2: After an accepted issue at clock edge k, the phases run as follows:
  - `busy` is high for cycles k+1 to k+4.
  - `mem_rd_en` is high only in cycle k+2.
  - `done` is high only in cycle k+4.
- R3: With bit 8 = 1 (banked), the data address is {`bank_sel`, f}, where f is bits [7:0].
- R4: With bit 8 = 0 and indexing not in force, f below 0x60 addresses 0x000+f and f of 0x60 or more addresses 0xF00+f.
- R5: With bit 8 = 0, `ext_en` = 1 and f at or below 0x5F, the address is (`idx_ptr` + f) modulo 4096.
- R6: With bit 9 = 1, the cycle carrying `done` has `mem_wr_en` = 1, `mem_wdata` = W AND operand and `mem_addr` = the read address, and `w_we` stays 0.
- R7: With bit 9 = 0, the cycle carrying `done` has `w_we` = 1 and `w_wdata` = W AND operand, and `mem_wr_en` stays 0 for the whole instruction.
- R8: On the edge that ends the `done` cycle, `flag_n` takes bit 7 of the result and `flag_z` takes (result == 0). At all other times both flags hold.
- R9: An `issue` presented while `busy` is high is ignored: no second sequence starts and the block returns to idle after the first `done`.
- R10: After reset the outputs are as follows: `busy`, `done`, `mem_rd_en`, `mem_wr_en`, `w_we`, `flag_n` and `flag_z` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Presents `instr` for acceptance |
| instr | input | 16 | Instruction word (opcode, d, a, f) |
| ext_en | input | 1 | Enables indexed mode for low file values |
| bank_sel | input | 4 | Bank register, upper address bits in banked mode |
| idx_ptr | input | 12 | Index pointer for indexed mode |
| w_in | input | 8 | Current working register value |
| mem_addr | output | 12 | Data-memory address |
| mem_rd_en | output | 1 | Synchronous read request |
| mem_rdata | input | 8 | Read data, valid the cycle after the request |
| mem_wr_en | output | 1 | Data-memory write enable |
| mem_wdata | output | 8 | Data-memory write data |
| w_we | output | 1 | Working register write strobe |
| w_wdata | output | 8 | Working register write data |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| busy | output | 1 | An instruction is in flight |
| done | output | 1 | Write phase of the instruction |

## Verification
The embedded assertions check the phase structure on every cycle:
- A read always precedes `done` by two cycles.
- The two write strobes are never high together, and a memory write only appears with `done`.
- The high access window produces a top-page address.
- The flags move only after `done`, and the zero flag tracks the committed value.

Only the directed scenarios can show the rest:
- The numeric address each mode produces, including the pointer wrap and the 0x5F/0x60 boundary.
- The actual AND values and where they land.
- That a rejected opcode or an overlapping issue leaves memory, W and the flags untouched.

// File: rtl/fileop_pkg.sv
package fileop_pkg;

  localparam logic [5:0] OPC_AND_FILE = 6'b000101;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_DEC  = 3'd1,
    PH_RD   = 3'd2,
    PH_PROC = 3'd3,
    PH_WR   = 3'd4
  } phase_t;

  typedef struct packed {
    logic       to_file;   // destination: 1 = memory byte, 0 = working register
    logic       banked;    // 1 = bank register gives upper address bits
    logic [7:0] fsel;      // file field
  } op_fields_t;

endpackage

// File: rtl/fileop_phase_seq.sv
module fileop_phase_seq
  import fileop_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   issue,
  input  logic   opc_ok,
  output phase_t phase,
  output logic   accept
);

  phase_t phase_d;

  always_comb begin
    accept  = 1'b0;
    phase_d = phase;
    unique case (phase)
      PH_IDLE: begin
        if (issue && opc_ok) begin
          accept  = 1'b1;
          phase_d = PH_DEC;
        end
      end
      PH_DEC:  phase_d = PH_RD;
      PH_RD:   phase_d = PH_PROC;
      PH_PROC: phase_d = PH_WR;
      PH_WR:   phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_d;
  end

  // R9: a busy sequence never restarts at decode except from idle
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DEC) |-> ($past(phase) == PH_IDLE));

endmodule

// File: rtl/fileop_addr_gen.sv
module fileop_addr_gen #(
  parameter int ADDR_W    = 12,
  parameter int FILE_W    = 8,
  parameter int ACC_SPLIT = 8'h60,
  localparam int HI_W     = ADDR_W - FILE_W
) (
  input  logic [FILE_W-1:0] fsel,
  input  logic              banked,
  input  logic              ext_en,
  input  logic [HI_W-1:0]   bank,
  input  logic [ADDR_W-1:0] idx,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              indexed
);

  logic [ADDR_W-1:0] f_zext;
  logic              low_half;

  always_comb begin
    f_zext   = {{HI_W{1'b0}}, fsel};
    low_half = (fsel < FILE_W'(ACC_SPLIT));
    indexed  = !banked && ext_en && low_half;
    if (banked)       eff_addr = {bank, fsel};
    else if (indexed) eff_addr = idx + f_zext;     // carry out of the top bit dropped
    else if (low_half) eff_addr = f_zext;
    else              eff_addr = {{HI_W{1'b1}}, fsel};
  end

endmodule

// File: rtl/fileop_and_dp.sv
module fileop_and_dp #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              commit,
  input  logic [DATA_W-1:0] w_val,
  input  logic [DATA_W-1:0] mem_val,
  output logic [DATA_W-1:0] result,
  output logic              flag_n,
  output logic              flag_z
);

  logic [DATA_W-1:0] result_d;
  logic              flag_n_d, flag_z_d;

  always_comb begin
    result_d = capture ? (w_val & mem_val) : result;
    flag_n_d = commit ? result[DATA_W-1] : flag_n;
    flag_z_d = commit ? (result == '0)   : flag_z;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
    end else begin
      result <= result_d;
      flag_n <= flag_n_d;
      flag_z <= flag_z_d;
    end
  end

  // R8: flags move only on a commit edge
  a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(commit) |-> $stable({flag_n, flag_z}));

  // R8: zero flag reflects the committed result
  a_r8_zero_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    $past(commit) |-> (flag_z == ($past(result) == '0)));

endmodule

// File: rtl/fileop_and_core.sv
module fileop_and_core
  import fileop_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 8,
  parameter int FILE_W    = 8,
  parameter int ACC_SPLIT = 8'h60,
  localparam int BANK_W   = ADDR_W - FILE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [15:0]       instr,
  input  logic              ext_en,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [ADDR_W-1:0] idx_ptr,
  input  logic [DATA_W-1:0] w_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_en,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_wr_en,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              w_we,
  output logic [DATA_W-1:0] w_wdata,
  output logic              flag_n,
  output logic              flag_z,
  output logic              busy,
  output logic              done
);

  phase_t            phase;
  logic              accept;
  logic              opc_ok;
  op_fields_t        fld_q, fld_d;
  logic [ADDR_W-1:0] addr_q, addr_d, addr_calc;
  logic              idx_mode;
  logic [DATA_W-1:0] result;

  assign opc_ok = (instr[15:10] == OPC_AND_FILE);

  fileop_phase_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .issue  (issue),
    .opc_ok (opc_ok),
    .phase  (phase),
    .accept (accept)
  );

  fileop_addr_gen #(
    .ADDR_W    (ADDR_W),
    .FILE_W    (FILE_W),
    .ACC_SPLIT (ACC_SPLIT)
  ) u_addr (
    .fsel     (fld_q.fsel),
    .banked   (fld_q.banked),
    .ext_en   (ext_en),
    .bank     (bank_sel),
    .idx      (idx_ptr),
    .eff_addr (addr_calc),
    .indexed  (idx_mode)
  );

  fileop_and_dp #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (phase == PH_PROC),
    .commit  (phase == PH_WR),
    .w_val   (w_in),
    .mem_val (mem_rdata),
    .result  (result),
    .flag_n  (flag_n),
    .flag_z  (flag_z)
  );

  // next-state for decoded fields and address
  always_comb begin
    fld_d  = accept ? op_fields_t'(instr[9:0]) : fld_q;
    addr_d = (phase == PH_DEC) ? addr_calc : addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q  <= '0;
      addr_q <= '0;
    end else begin
      fld_q  <= fld_d;
      addr_q <= addr_d;
    end
  end

  always_comb begin
    busy      = (phase != PH_IDLE);
    done      = (phase == PH_WR);
    mem_addr  = addr_q;
    mem_rd_en = (phase == PH_RD);
    mem_wr_en = done && fld_q.to_file;
    mem_wdata = result;
    w_we      = done && !fld_q.to_file;
    w_wdata   = result;
  end

  // R2: done always comes two cycles after the read request
  a_r2_read_before_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_rd_en, 2));

  // R6: a memory write only ever occurs in the done cycle
  a_r6_write_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> done);

  // R7: the two destinations are exclusive
  a_r7_one_dest: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr_en && w_we));

  // R4: high access window lands on the top page
  a_r4_high_window: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && !fld_q.banked && (fld_q.fsel >= FILE_W'(ACC_SPLIT)))
      |-> (mem_addr[ADDR_W-1:FILE_W] == {BANK_W{1'b1}}));

  // R5: indexed mode is only chosen for low file values
  a_r5_idx_low_only: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DEC && idx_mode) |-> (fld_q.fsel < FILE_W'(ACC_SPLIT)));

endmodule

// File: tb/tb_fileop_and_core.sv
`timescale 1ns/1ps
module tb_fileop_and_core;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue;
  logic [15:0] instr;
  logic        ext_en;
  logic [3:0]  bank_sel;
  logic [11:0] idx_ptr;
  logic [7:0]  w_in;
  logic [11:0] mem_addr;
  logic        mem_rd_en;
  logic [7:0]  mem_rdata;
  logic        mem_wr_en;
  logic [7:0]  mem_wdata;
  logic        w_we;
  logic [7:0]  w_wdata;
  logic        flag_n, flag_z, busy, done;

  logic [7:0]  mem [4096];
  int checks = 0;
  int fails  = 0;
  logic exp_n = 1'b0, exp_z = 1'b0;

  always #2.5 clk = ~clk;

  fileop_and_core dut (
    .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr), .ext_en(ext_en),
    .bank_sel(bank_sel), .idx_ptr(idx_ptr), .w_in(w_in), .mem_addr(mem_addr),
    .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata), .mem_wr_en(mem_wr_en),
    .mem_wdata(mem_wdata), .w_we(w_we), .w_wdata(w_wdata), .flag_n(flag_n),
    .flag_z(flag_z), .busy(busy), .done(done)
  );

  always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic d, input logic a, input logic [7:0] f);
    return {6'b000101, d, a, f};
  endfunction

  // Run one accepted instruction; poke != 0 pulses a second issue while busy.
  task automatic run_op(input string tag, input logic d, input logic a, input logic [7:0] f,
                        input logic ext, input logic [3:0] bsr, input logic [11:0] idx,
                        input logic [11:0] exp_addr, input bit poke);
    logic [7:0] res;
    logic [7:0] old_mem;
    logic [7:0] old_w;
    old_mem = mem[exp_addr];
    old_w   = w_in;
    res     = w_in & mem[exp_addr];
    ext_en = ext; bank_sel = bsr; idx_ptr = idx;
    instr = mk(d, a, f); issue = 1'b1;
    @(negedge clk); issue = 1'b0;                       // decode
    chk({tag, " R2 busy"}, busy, 1);
    chk({tag, " R2 no rd in decode"}, mem_rd_en, 0);
    @(negedge clk);                                     // read
    chk({tag, " R2 rd_en"}, mem_rd_en, 1);
    chk({tag, " addr"}, mem_addr, exp_addr);
    if (poke) begin instr = mk(~d, 1'b1, 8'h01); issue = 1'b1; end
    @(negedge clk); issue = 1'b0;                       // process
    chk({tag, " R2 no done yet"}, done, 0);
    @(negedge clk);                                     // write
    chk({tag, " R2 done"}, done, 1);
    chk({tag, " R6 mem_wr_en"}, mem_wr_en, d);
    chk({tag, " R7 w_we"}, w_we, !d);
    if (d) begin
      chk({tag, " R6 wdata"}, mem_wdata, res);
      chk({tag, " R6 waddr"}, mem_addr, exp_addr);
      mem[mem_addr] = mem_wdata;
    end else begin
      chk({tag, " R7 w_wdata"}, w_wdata, res);
      w_in = w_wdata;
    end
    exp_n = res[7]; exp_z = (res == 8'h00);
    @(negedge clk);                                     // idle
    chk({tag, " R2 done low"}, done, 0);
    chk({tag, " R9 idle after one op"}, busy, 0);
    chk({tag, " R8 flags"}, {flag_n, flag_z}, {exp_n, exp_z});
    if (d) chk({tag, " R6 W untouched"}, w_in, old_w);
    else   chk({tag, " R7 mem untouched"}, mem[exp_addr], old_mem);
    if (poke) begin
      @(negedge clk);
      chk({tag, " R9 no second start"}, busy, 0);
    end
  endtask

  task automatic t_reset;
    chk("R10 busy", busy, 0);
    chk("R10 done", done, 0);
    chk("R10 enables", {mem_rd_en, mem_wr_en, w_we}, 0);
    chk("R10 flags", {flag_n, flag_z}, 0);
  endtask

  task automatic t_bad_opcode;
    instr = 16'h1A55; issue = 1'b1;                     // bits [15:10] = 000110
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); issue = 1'b0;
      chk("R1 no busy", busy, 0);
      chk("R1 no access", {mem_rd_en, mem_wr_en, w_we, done}, 0);
    end
    chk("R1 flags held", {flag_n, flag_z}, {exp_n, exp_z});
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 37 + 5);
    rst_n = 1'b0; issue = 1'b0; instr = '0; ext_en = 1'b0;
    bank_sel = '0; idx_ptr = '0; w_in = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    // R4 R7: low access window, result to W (0x17 & 0xC2 = 0x02)
    mem[12'h020] = 8'hC2; w_in = 8'h17;
    run_op("R4/R7 low access", 1'b0, 1'b0, 8'h20, 1'b0, 4'h0, 12'h000, 12'h020, 0);
    chk("R7 W value", w_in, 8'h02);
    // R3 R6 R8: banked, write back, negative result
    mem[12'h533] = 8'hF0; w_in = 8'h9C;
    run_op("R3/R6 banked", 1'b1, 1'b1, 8'h33, 1'b1, 4'h5, 12'h123, 12'h533, 0);
    chk("R6 mem value", mem[12'h533], 8'h90);
    chk("R8 negative", flag_n, 1);
    // R4: high access window
    w_in = 8'hFF;
    run_op("R4 high access", 1'b0, 1'b0, 8'h80, 1'b0, 4'h7, 12'h000, 12'hF80, 0);
    // R5: indexed, boundary 0x5F
    run_op("R5 indexed", 1'b1, 1'b0, 8'h5F, 1'b1, 4'h2, 12'h3A0, 12'h3FF, 0);
    // R5: pointer wrap
    run_op("R5 wrap", 1'b0, 1'b0, 8'h0C, 1'b1, 4'h2, 12'hFFA, 12'h006, 0);
    // R4: 0x60 with extended mode is not indexed
    run_op("R4 ext at 0x60", 1'b0, 1'b0, 8'h60, 1'b1, 4'h2, 12'h400, 12'hF60, 0);
    // R8: zero result
    mem[12'h0A4] = 8'h0F; w_in = 8'hF0;
    run_op("R8 zero", 1'b1, 1'b1, 8'hA4, 1'b0, 4'h0, 12'h000, 12'h0A4, 0);
    chk("R8 zero flag", flag_z, 1);
    // R1: rejected opcode
    t_bad_opcode();
    // R9: issue during busy ignored
    mem[12'h345] = 8'h3C; w_in = 8'h66;
    run_op("R9 overlap", 1'b0, 1'b1, 8'h45, 1'b0, 4'h3, 12'h000, 12'h345, 1);
    chk("R9 W value", w_in, 8'h24);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule